// File: doc/BRIEF.md
# In-Order Five-Stage Interlocked Integer Pipeline

This block is a scalar integer pipeline with five stages: fetch, primary decode, secondary decode, execute and write-back. Each stage holds at most one instruction. It runs a two-operand toy instruction set over eight 16-bit registers. The instruction set has XOR, ADD and load-immediate. Programs sit in a small instruction store that is written through a load port and then fetched from address zero after reset. Fetch runs through the store once and then stops issuing, so a program never wraps around and executes twice.

The block has no operand forwarding. A hazard interlock stops the instruction in primary decode whenever that instruction reads a register still owed by an older instruction in secondary decode or execute. During the stop, fetch and the program counter hold, and an empty slot enters secondary decode. The register file is write-first, so a result written in write-back is visible to decode in the same cycle. A dependent neighbour therefore waits exactly two cycles, and a run of dependent operations is fully serialised.

A debug read port exposes the register file. Two counters report the number of stalled cycles and the number of completed instructions. Together they let a bench confirm the exact number of bubbles that a program costs.

Top module: `pipe_core`

## Requirements
- R1: An instruction word has the operation in bits [15:14] (01 XOR, 10 ADD, 11 load-immediate, 00 empty slot), the destination register in [13:11], the source register in [10:8] and an 8-bit immediate in [7:0]. An empty-slot word is never issued, changes no register and is not counted, whatever its other bits hold.
- R2: XOR sets dst = dst ^ src. ADD sets dst = dst + src modulo 2^16. Load-immediate sets dst to the zero-extended immediate. Results land in the register file at the end of write-back.
- R3: Register 0 always reads zero and ignores writes. An older instruction naming register 0 as its destination never causes a stall.
- R4: When the instruction in primary decode is XOR or ADD and either of its registers is the nonzero destination of a valid instruction in secondary decode or execute, the program counter, the fetch stage and primary decode all hold. An empty slot enters secondary decode, while execute and write-back keep advancing.
- R5: The register file is write-first, so the interlock never waits on write-back. A reader directly behind its producer stalls exactly 2 cycles, a reader two slots behind stalls 1 cycle, and a reader three or more slots behind does not stall.
- R6: The three-XOR register swap run back to back gives the same register contents as sequential execution, at a cost of exactly 4 stall cycles.
- R7: stall_count rises by one for each stalled cycle. retire_count rises by one for each instruction that leaves write-back. Both counters are zero after reset.
- R8: Words written through the load port are fetched in address order starting at 0 after reset. Once the last address has been fetched, fetch issues nothing more and does not wrap.
- R9: dbg_rdata shows the current contents of the register selected by dbg_raddr. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restarts fetch at address 0 |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IMEM_AW | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to store |
| dbg_raddr | input | 3 | Register index for the debug read |
| dbg_rdata | output | 16 | Contents of the selected register |
| stall_o | output | 1 | High in each cycle in which primary decode is held |
| stall_count | output | CNT_W | Number of stalled cycles since reset |
| retire_count | output | CNT_W | Number of completed instructions since reset |

## Verification
Each program is chosen so that its final registers and its exact stall count separate one timing rule from the others. A set of independent loads checks plain flow with no stalls. The padded swap isolates the two-cycle penalty for a reader directly behind its producer, and a pair placed two slots apart gives the one-cycle case. Writing register 0 just ahead of a reader shows that register 0 raises no hazard. A nine-long chain of self-adds checks both the full serialisation and 16-bit wraparound, and any re-fetch of the program would corrupt its result. Words in the empty-slot encoding that carry nonzero fields show that such slots neither execute nor count, yet still act as spacing between a producer and its reader.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

    localparam int DATA_W = 16;
    localparam int INSN_W = 16;
    localparam int NREGS  = 8;
    localparam int RA_W   = $clog2(NREGS);
    localparam int IMM_W  = 8;

    typedef enum logic [1:0] {
        OP_EMPTY = 2'b00,
        OP_XOR   = 2'b01,
        OP_ADD   = 2'b10,
        OP_LDI   = 2'b11
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [INSN_W-1:0] word;
    } raw_slot_t;

    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [RA_W-1:0]   dst;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [IMM_W-1:0]  imm;
    } opnd_slot_t;

    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [RA_W-1:0]   dst;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
    } exec_slot_t;

    typedef struct packed {
        logic              valid;
        logic [RA_W-1:0]   dst;
        logic [DATA_W-1:0] value;
    } wb_slot_t;

    function automatic op_e word_op(input logic [INSN_W-1:0] w);
        return op_e'(w[15:14]);
    endfunction

    function automatic logic [RA_W-1:0] word_dst(input logic [INSN_W-1:0] w);
        return w[13:11];
    endfunction

    function automatic logic [RA_W-1:0] word_src(input logic [INSN_W-1:0] w);
        return w[10:8];
    endfunction

endpackage

// File: rtl/pipe_imem.sv
module pipe_imem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile
    import pipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RA_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RA_W-1:0]   ra_a,
    output logic [DATA_W-1:0] rd_a,
    input  logic [RA_W-1:0]   ra_b,
    output logic [DATA_W-1:0] rd_b,
    input  logic [RA_W-1:0]   ra_dbg,
    output logic [DATA_W-1:0] rd_dbg
);

    logic [DATA_W-1:0] regs_q [NREGS];
    logic              wr_live;

    assign wr_live = we && (waddr != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_live) begin
            regs_q[waddr] <= wdata;
        end
    end

    // write-first: a value being written this cycle is seen by readers now
    function automatic logic [DATA_W-1:0] rd_port(input logic [RA_W-1:0] a);
        if (a == '0) begin
            return '0;
        end
        if (wr_live && (a == waddr)) begin
            return wdata;
        end
        return regs_q[a];
    endfunction

    assign rd_a   = rd_port(ra_a);
    assign rd_b   = rd_port(ra_b);
    assign rd_dbg = regs_q[ra_dbg];

endmodule

// File: rtl/pipe_hazard.sv
module pipe_hazard
    import pipe_pkg::*;
#(
    parameter int NPROD = 2
) (
    input  logic                       cons_valid,
    input  op_e                        cons_op,
    input  logic [RA_W-1:0]            cons_dst,
    input  logic [RA_W-1:0]            cons_src,
    input  logic [NPROD-1:0]           prod_valid,
    input  logic [NPROD-1:0][RA_W-1:0] prod_dst,
    output logic                       stall
);

    logic             reads_regs;
    logic [NPROD-1:0] hit;

    assign reads_regs = cons_valid && ((cons_op == OP_XOR) || (cons_op == OP_ADD));

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        assign hit[p] = prod_valid[p] && (prod_dst[p] != '0) &&
                        ((prod_dst[p] == cons_dst) || (prod_dst[p] == cons_src));
    end

    assign stall = reads_regs && (|hit);

endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
    import pipe_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        unique case (op)
            OP_XOR:  result = opa ^ opb;
            OP_ADD:  result = opa + opb;
            OP_LDI:  result = opb;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/pipe_core.sv
module pipe_core
    import pipe_pkg::*;
#(
    parameter int  IMEM_DEPTH = 16,
    parameter int  CNT_W      = 16,
    localparam int IMEM_AW    = $clog2(IMEM_DEPTH),
    localparam int PCW        = IMEM_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_waddr,
    input  logic [INSN_W-1:0]  imem_wdata,
    input  logic [RA_W-1:0]    dbg_raddr,
    output logic [DATA_W-1:0]  dbg_rdata,
    output logic               stall_o,
    output logic [CNT_W-1:0]   stall_count,
    output logic [CNT_W-1:0]   retire_count
);

    typedef struct packed {
        logic [PCW-1:0]   pc;
        raw_slot_t        fe;
        raw_slot_t        de1;
        opnd_slot_t       de2;
        exec_slot_t       ex;
        wb_slot_t         wb;
        logic [CNT_W-1:0] n_stall;
        logic [CNT_W-1:0] n_retire;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [INSN_W-1:0] fetch_word;
    logic              fetch_open;
    logic              stall;
    logic [DATA_W-1:0] rf_a, rf_b;
    logic [DATA_W-1:0] alu_y;
    op_e               de1_op;
    logic [RA_W-1:0]   de1_dst, de1_src;

    // observation points for the bound checker
    logic               d1_valid, d2_valid, wb_valid;
    logic [INSN_W-1:0]  d1_word;
    logic [PCW-1:0]     pc_now;

    assign de1_op  = word_op(st_q.de1.word);
    assign de1_dst = word_dst(st_q.de1.word);
    assign de1_src = word_src(st_q.de1.word);

    pipe_imem #(
        .DEPTH (IMEM_DEPTH),
        .WIDTH (INSN_W)
    ) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (st_q.pc[IMEM_AW-1:0]),
        .rdata (fetch_word)
    );

    pipe_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_q.wb.valid),
        .waddr  (st_q.wb.dst),
        .wdata  (st_q.wb.value),
        .ra_a   (de1_dst),
        .rd_a   (rf_a),
        .ra_b   (de1_src),
        .rd_b   (rf_b),
        .ra_dbg (dbg_raddr),
        .rd_dbg (dbg_rdata)
    );

    pipe_hazard #(
        .NPROD (2)
    ) u_hz (
        .cons_valid (st_q.de1.valid),
        .cons_op    (de1_op),
        .cons_dst   (de1_dst),
        .cons_src   (de1_src),
        .prod_valid ({st_q.ex.valid, st_q.de2.valid}),
        .prod_dst   ({st_q.ex.dst, st_q.de2.dst}),
        .stall      (stall)
    );

    pipe_alu u_alu (
        .op     (st_q.ex.op),
        .opa    (st_q.ex.opa),
        .opb    (st_q.ex.opb),
        .result (alu_y)
    );

    assign fetch_open = (st_q.pc < PCW'(IMEM_DEPTH));

    always_comb begin
        st_d = st_q;

        // front stages: advance unless the interlock holds primary decode
        if (!stall) begin
            st_d.pc       = fetch_open ? st_q.pc + PCW'(1) : st_q.pc;
            st_d.fe.valid = fetch_open && (word_op(fetch_word) != OP_EMPTY);
            st_d.fe.word  = fetch_word;
            st_d.de1      = st_q.fe;
            st_d.de2.valid = st_q.de1.valid;
            st_d.de2.op    = de1_op;
            st_d.de2.dst   = de1_dst;
            st_d.de2.opa   = rf_a;
            st_d.de2.opb   = rf_b;
            st_d.de2.imm   = st_q.de1.word[IMM_W-1:0];
        end else begin
            st_d.de2 = '0;
        end

        // secondary decode: pick the second operand
        st_d.ex.valid = st_q.de2.valid;
        st_d.ex.op    = st_q.de2.op;
        st_d.ex.dst   = st_q.de2.dst;
        st_d.ex.opa   = st_q.de2.opa;
        st_d.ex.opb   = (st_q.de2.op == OP_LDI) ? DATA_W'(st_q.de2.imm) : st_q.de2.opb;

        // execute into write-back
        st_d.wb.valid = st_q.ex.valid;
        st_d.wb.dst   = st_q.ex.dst;
        st_d.wb.value = alu_y;

        st_d.n_stall  = st_q.n_stall + CNT_W'(stall);
        st_d.n_retire = st_q.n_retire + CNT_W'(st_q.wb.valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_o      = stall;
    assign stall_count  = st_q.n_stall;
    assign retire_count = st_q.n_retire;

    assign d1_valid = st_q.de1.valid;
    assign d1_word  = st_q.de1.word;
    assign d2_valid = st_q.de2.valid;
    assign wb_valid = st_q.wb.valid;
    assign pc_now   = st_q.pc;

endmodule

// File: rtl/pipe_core_chk.sv
module pipe_core_chk #(
    parameter int CNT_W      = 16,
    parameter int PCW        = 5,
    parameter int IMEM_DEPTH = 16,
    parameter int INSN_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              d1_valid,
    input logic [INSN_W-1:0] d1_word,
    input logic              d2_valid,
    input logic              wb_valid,
    input logic [PCW-1:0]    pc_now,
    input logic [CNT_W-1:0]  stall_count,
    input logic [CNT_W-1:0]  retire_count
);

    AST_BUBBLE_INTO_D2: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !d2_valid); // R4
    AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(pc_now)); // R4
    AST_D1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (d1_valid && $stable(d1_word))); // R4
    AST_STALL_TALLY: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (stall_count == $past(stall_count) + CNT_W'(1))); // R7
    AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !stall |=> $stable(stall_count)); // R7
    AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !wb_valid |=> $stable(retire_count)); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (pc_now == PCW'(IMEM_DEPTH)) |=> (pc_now == PCW'(IMEM_DEPTH))); // R8

endmodule

bind pipe_core pipe_core_chk #(
    .CNT_W      (CNT_W),
    .PCW        (PCW),
    .IMEM_DEPTH (IMEM_DEPTH),
    .INSN_W     (INSN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall        (stall),
    .d1_valid     (d1_valid),
    .d1_word      (d1_word),
    .d2_valid     (d2_valid),
    .wb_valid     (wb_valid),
    .pc_now       (pc_now),
    .stall_count  (stall_count),
    .retire_count (retire_count)
);

// File: tb/sim_pipe_core.sv
`timescale 1ns/1ps
module sim_pipe_core;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_we = 1'b0;
    logic [AW-1:0] imem_waddr = '0;
    logic [15:0]   imem_wdata = '0;
    logic [2:0]    dbg_raddr = '0;
    logic [15:0]   dbg_rdata;
    logic          stall_o;
    logic [CW-1:0] stall_count;
    logic [CW-1:0] retire_count;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [15:0] prog [DEPTH];

    always #5 clk = ~clk;

    pipe_core #(.IMEM_DEPTH(DEPTH), .CNT_W(CW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .imem_we      (imem_we),
        .imem_waddr   (imem_waddr),
        .imem_wdata   (imem_wdata),
        .dbg_raddr    (dbg_raddr),
        .dbg_rdata    (dbg_rdata),
        .stall_o      (stall_o),
        .stall_count  (stall_count),
        .retire_count (retire_count)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] ldi(input int rd, input int imm);
        return {2'b11, 3'(rd), 3'b000, 8'(imm)};
    endfunction

    function automatic logic [15:0] rr(input logic [1:0] op, input int rd, input int rs);
        return {op, 3'(rd), 3'(rs), 8'h00};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int r, input logic [15:0] exp);
        @(negedge clk);
        dbg_raddr = 3'(r);
        #1;
        chk(req, $sformatf("r%0d", r), {16'h0, dbg_rdata}, {16'h0, exp});
    endtask

    task automatic clear_prog();
        for (int i = 0; i < DEPTH; i++) prog[i] = 16'h0000;
    endtask

    task automatic run_prog(input int n_cycles);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            imem_we    = 1'b1;
            imem_waddr = AW'(i);
            imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        rst_n   = 1'b1;
        repeat (n_cycles) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R7", "stall_count after reset", 32'(stall_count), 0);
        chk("R7", "retire_count after reset", 32'(retire_count), 0);
        chk("R4", "stall_o in reset", 32'(stall_o), 0);
        chk_reg("R9", 3, 16'h0000);
    endtask

    task automatic t_independent();
        clear_prog();
        prog[0] = ldi(1, 8'h05);
        prog[1] = ldi(2, 8'h09);
        prog[2] = ldi(3, 8'h20);
        prog[3] = ldi(7, 8'h7F);
        run_prog(40);
        chk_reg("R2", 1, 16'h0005);
        chk_reg("R2", 2, 16'h0009);
        chk_reg("R8", 3, 16'h0020);
        chk_reg("R9", 7, 16'h007F);
        chk("R5", "stalls independent", 32'(stall_count), 0);
        chk("R7", "retired independent", 32'(retire_count), 4);
    endtask

    task automatic t_swap();
        clear_prog();
        prog[0] = ldi(1, 8'h3C);
        prog[1] = ldi(2, 8'hA5);
        prog[2] = ldi(5, 8'h01);
        prog[3] = ldi(6, 8'h02);
        prog[4] = rr(2'b01, 1, 2);
        prog[5] = rr(2'b01, 2, 1);
        prog[6] = rr(2'b01, 1, 2);
        run_prog(50);
        chk_reg("R6", 1, 16'h00A5);
        chk_reg("R6", 2, 16'h003C);
        chk("R6", "swap stalls", 32'(stall_count), 4);
        chk("R7", "swap retired", 32'(retire_count), 7);
    endtask

    task automatic t_distance();
        clear_prog();
        prog[0] = ldi(4, 8'h10);
        prog[1] = ldi(5, 8'h11);
        prog[2] = ldi(6, 8'h12);
        prog[3] = ldi(0, 8'hFF);
        prog[4] = rr(2'b10, 4, 0);
        prog[5] = ldi(1, 8'h03);
        prog[6] = ldi(7, 8'h09);
        prog[7] = rr(2'b10, 1, 1);
        run_prog(50);
        chk_reg("R3", 0, 16'h0000);
        chk_reg("R3", 4, 16'h0010);
        chk_reg("R5", 1, 16'h0006);
        chk_reg("R2", 7, 16'h0009);
        chk("R5", "distance-two stalls, r0 no hazard", 32'(stall_count), 1);
        chk("R7", "distance retired", 32'(retire_count), 8);
    endtask

    task automatic t_chain();
        clear_prog();
        prog[0] = ldi(2, 8'hFF);
        for (int i = 1; i <= 9; i++) prog[i] = rr(2'b10, 2, 2);
        run_prog(80);
        chk_reg("R2", 2, 16'hFE00);
        chk("R5", "chain stalls", 32'(stall_count), 18);
        chk("R8", "chain retired, no refetch", 32'(retire_count), 10);
    endtask

    task automatic t_empty();
        clear_prog();
        prog[0] = ldi(7, 8'h44);
        prog[1] = 16'h3FFF;
        prog[2] = 16'h3FFF;
        prog[3] = rr(2'b10, 7, 7);
        run_prog(40);
        chk_reg("R1", 7, 16'h0088);
        chk("R1", "empty slots retired", 32'(retire_count), 2);
        chk("R1", "empty slot spacing stalls", 32'(stall_count), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_independent();
        t_swap();
        t_distance();
        t_chain();
        t_empty();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule